// File: doc/BRIEF.md
# Convolution Layer Tile Sequencer

This controller runs a layer-programmable convolution engine from a list of per-layer instruction words held in external memory. After a start pulse it fetches one instruction word into a local instruction register and decodes it into loop limits. It then walks the layer's tiles, and for each tile it issues a weight burst and an input burst, starts the compute engine and, when the output tile is complete, issues a store burst. When the layer's last output tile has been stored it fetches the next instruction. A fully connected layer is converted during decode into an equivalent convolution. The weight matrix becomes the input maps and the batch becomes the output maps. The same tile machinery then serves both layer kinds.

Memory traffic uses two request/acknowledge channels, each carrying a base address and a burst length in words. The load channel serves instruction, weight and input bursts one at a time. The store channel runs on its own, so the loads of tile k+1 proceed while output tile k drains. The host lays data out in tile order, so each stream (weights, input maps, output maps) advances through its region by a running pointer.

Top module: `cnn_tile_seq`

## Requirements
- R1: While `rst` is high and after it falls, `ld_req`, `st_req`, `cmp_start` and `done` are low until a start is accepted.
- R2: Each layer begins with exactly one load of kind 0 (instruction) at address INSTR_BASE plus the layer index and length 1. It comes before any other load of that layer, and the word returned with its acknowledge is that layer's instruction.
- R3: An instruction word is packed, most significant field first, as: kind flag (1 bit, 1 = fully connected), inputs (16), outputs (16), rows (12), columns (12), kernel (4), stride (4), pad (4), activation enable (1), pool size (4).
- R4: Tiles are visited with input-feature groups of TN innermost, then output-feature groups of TM, then column tiles of TC, then row tiles of TR outermost. Each extent is the smaller of the tile size and what remains of the layer dimension.
- R5: Each tile's weight load has kind 1, length tm*tn*kh*kw, and address WGT_BASE plus the sum of all earlier weight lengths since start.
- R6: Each tile's input load has kind 2 and length tn*ih*iw with ih=(tr-1)*S+kh and iw=(tc-1)*S+kw. The pad is subtracted from ih at the first and at the last row tile, and from iw at the first and at the last column tile. The address is IFM_BASE plus the sum of earlier input lengths.
- R7: A store is issued only after the last input-feature group of an output tile has been computed. Its length is tm*tr*tc and its address is OFM_BASE plus the sum of earlier store lengths. No store follows the other groups.
- R8: `cmp_start` rises only when both loads of the tile are acknowledged and no store is outstanding. After a compute, the next tile's loads are issued while the previous store may still be outstanding.
- R9: Within a tile the weight load precedes the input load. A request stays high with stable kind, address and length until acknowledged, and a new one is not issued until the previous one is acknowledged.
- R10: A fully connected instruction with N inputs, M outputs, batch B in the rows field and log2 of the factor ker in the kernel field runs as a convolution with N/ker input maps, B output maps, 1 row, M columns, kernel 1 by ker, stride ker and no pad.
- R11: `start` with a nonzero `layer_cnt` runs that many layers back to back. `done` pulses for one cycle after the final store of the last layer is acknowledged. `start` with `layer_cnt` of 0 issues no request.
- R12: With each `cmp_start`, `cmp_clear` is high exactly for the first input-feature group of an output tile. `cmp_relu` and `cmp_pool` carry the instruction's activation and pool fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run while idle |
| layer_cnt | input | CNT_W | Number of layers to run, sampled at start |
| ld_req | output | 1 | Load request |
| ld_kind | output | 2 | Load kind: 0 instruction, 1 weight, 2 input |
| ld_addr | output | ADDR_W | Load base address |
| ld_len | output | LEN_W | Load burst length in words |
| ld_ack | input | 1 | Load acknowledge, one cycle |
| ld_rdata | input | INSTR_W | Instruction word returned with an instruction acknowledge |
| st_req | output | 1 | Store request |
| st_addr | output | ADDR_W | Store base address |
| st_len | output | LEN_W | Store burst length in words |
| st_ack | input | 1 | Store acknowledge, one cycle |
| cmp_start | output | 1 | Start pulse to the compute engine |
| cmp_clear | output | 1 | Clear accumulators for this tile |
| cmp_relu | output | 1 | Activation enable for the layer |
| cmp_pool | output | 4 | Pool size for the layer |
| cmp_done | input | 1 | Compute engine finished the tile |
| done | output | 1 | All layers finished, one-cycle pulse |

## Verification
The bench uses a layer with pad and partial tiles in every dimension. A design with a wrong min() or edge-pad term issues a wrong input or store length at the ragged tiles. A fully connected layer follows. A decoder that skips the rewrite requests the raw weight matrix with a square kernel and gets every length wrong. A layer with more input groups than one tile catches a design that stores after every group or clears on every group. Store acknowledges are slow, so the load/store overlap is visible. A sequencer that starts compute while a store drains, or that issues a second request before an acknowledge, shows up at the compute engine and memory monitors.

// File: rtl/cnn_seq_pkg.sv
package cnn_seq_pkg;

  localparam int DIM_W = 16;

  // Packed instruction word, most significant field first.
  typedef struct packed {
    logic        is_fcn;
    logic [15:0] n_in;
    logic [15:0] n_out;
    logic [11:0] rows;
    logic [11:0] cols;
    logic [3:0]  kern;
    logic [3:0]  stride;
    logic [3:0]  pad;
    logic        relu;
    logic [3:0]  pool;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  // Convolution view of a layer after decode.
  typedef struct packed {
    logic [DIM_W-1:0] n;
    logic [DIM_W-1:0] m;
    logic [DIM_W-1:0] r;
    logic [DIM_W-1:0] c;
    logic [DIM_W-1:0] kh;
    logic [DIM_W-1:0] kw;
    logic [DIM_W-1:0] s;
    logic [DIM_W-1:0] pad;
    logic             relu;
    logic [3:0]       pool;
  } layer_cfg_t;

  localparam logic [1:0] KIND_INSTR = 2'd0;
  localparam logic [1:0] KIND_WGT   = 2'd1;
  localparam logic [1:0] KIND_IFM   = 2'd2;

endpackage

// File: rtl/cnn_instr_decode.sv
module cnn_instr_decode
  import cnn_seq_pkg::*;
(
  input  instr_t     instr,
  output layer_cfg_t cfg
);

  // R10: fully connected layers become a 1-row convolution, weight-major.
  always_comb begin
    cfg.relu = instr.relu;
    cfg.pool = instr.pool;
    if (instr.is_fcn) begin
      cfg.n   = instr.n_in >> instr.kern;
      cfg.m   = DIM_W'(instr.rows);
      cfg.r   = DIM_W'(1);
      cfg.c   = instr.n_out;
      cfg.kh  = DIM_W'(1);
      cfg.kw  = DIM_W'(1) << instr.kern;
      cfg.s   = DIM_W'(1) << instr.kern;
      cfg.pad = '0;
    end else begin
      cfg.n   = instr.n_in;
      cfg.m   = instr.n_out;
      cfg.r   = DIM_W'(instr.rows);
      cfg.c   = DIM_W'(instr.cols);
      cfg.kh  = DIM_W'(instr.kern);
      cfg.kw  = DIM_W'(instr.kern);
      cfg.s   = DIM_W'(instr.stride);
      cfg.pad = DIM_W'(instr.pad);
    end
  end

endmodule

// File: rtl/cnn_tile_iter.sv
module cnn_tile_iter #(
  parameter int TR    = 2,
  parameter int TC    = 4,
  parameter int TM    = 2,
  parameter int TN    = 4,
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             adv,
  input  logic [DIM_W-1:0] lim_r,
  input  logic [DIM_W-1:0] lim_c,
  input  logic [DIM_W-1:0] lim_m,
  input  logic [DIM_W-1:0] lim_n,
  output logic [DIM_W-1:0] ext_r,
  output logic [DIM_W-1:0] ext_c,
  output logic [DIM_W-1:0] ext_m,
  output logic [DIM_W-1:0] ext_n,
  output logic             first_r,
  output logic             last_r,
  output logic             first_c,
  output logic             last_c,
  output logic             first_n,
  output logic             last_n,
  output logic             last_tile
);

  // Dimension 0 is innermost (input groups), 3 outermost (rows).
  localparam int ND = 4;

  function automatic int tsz(input int d);
    case (d)
      0:       return TN;
      1:       return TM;
      2:       return TC;
      default: return TR;
    endcase
  endfunction

  logic [ND-1:0][DIM_W-1:0] lim, org, ext;
  logic [ND-1:0][DIM_W:0]   nxt;
  logic [ND-1:0]            last, first;
  logic [ND:0]              carry;

  assign lim = {lim_r, lim_c, lim_m, lim_n};

  always_comb begin
    carry[0] = 1'b1;
    for (int d = 0; d < ND; d++) begin
      nxt[d]      = {1'b0, org[d]} + (DIM_W+1)'(tsz(d));
      last[d]     = nxt[d] >= {1'b0, lim[d]};
      first[d]    = org[d] == '0;
      ext[d]      = ((lim[d] - org[d]) < DIM_W'(tsz(d))) ? (lim[d] - org[d]) : DIM_W'(tsz(d));
      carry[d+1]  = carry[d] & last[d];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      org <= '0;
    end else if (adv) begin
      for (int d = 0; d < ND; d++)
        if (carry[d]) org[d] <= last[d] ? '0 : nxt[d][DIM_W-1:0];
    end
  end

  assign {ext_r, ext_c, ext_m, ext_n} = ext;
  assign first_n   = first[0];
  assign last_n    = last[0];
  assign first_c   = first[2];
  assign last_c    = last[2];
  assign first_r   = first[3];
  assign last_r    = last[3];
  assign last_tile = &last;

  // R4: an outer counter moves only when every inner one wraps.
  for (genvar d = 1; d < ND; d++) begin : g_order
    a_r4_outer_hold: assert property (@(posedge clk) disable iff (rst)
      (adv && !carry[d]) |=> $stable(org[d]));
  end

  a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
    adv |-> !last_tile);

endmodule

// File: rtl/cnn_tile_seq.sv
module cnn_tile_seq
  import cnn_seq_pkg::*;
#(
  parameter int TR     = 2,
  parameter int TC     = 4,
  parameter int TM     = 2,
  parameter int TN     = 4,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter logic [ADDR_W-1:0] INSTR_BASE = 'h1000,
  parameter logic [ADDR_W-1:0] WGT_BASE   = 'h10_0000,
  parameter logic [ADDR_W-1:0] IFM_BASE   = 'h40_0000,
  parameter logic [ADDR_W-1:0] OFM_BASE   = 'h80_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CNT_W-1:0]   layer_cnt,
  output logic               ld_req,
  output logic [1:0]         ld_kind,
  output logic [ADDR_W-1:0]  ld_addr,
  output logic [LEN_W-1:0]   ld_len,
  input  logic               ld_ack,
  input  logic [INSTR_W-1:0] ld_rdata,
  output logic               st_req,
  output logic [ADDR_W-1:0]  st_addr,
  output logic [LEN_W-1:0]   st_len,
  input  logic               st_ack,
  output logic               cmp_start,
  output logic               cmp_clear,
  output logic               cmp_relu,
  output logic [3:0]         cmp_pool,
  input  logic               cmp_done,
  output logic               done
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DECODE, S_LOAD, S_COMP, S_DRAIN} state_e;
  typedef enum logic [2:0] {LS_IDLE, LS_W_ISSUE, LS_W_WAIT, LS_I_ISSUE, LS_I_WAIT} ldst_e;

  state_e            state;
  ldst_e             ld_st;
  instr_t            instr_q;
  layer_cfg_t        dec_cfg, cfg_q;
  logic [CNT_W-1:0]  layer_idx, layer_cnt_q;
  logic [ADDR_W-1:0] wptr, iptr, optr;

  logic [DIM_W-1:0]  ext_r, ext_c, ext_m, ext_n;
  logic first_r, last_r, first_c, last_c, first_n, last_n, last_tile;
  logic it_init, it_adv;

  cnn_instr_decode u_dec (.instr(instr_q), .cfg(dec_cfg));

  assign it_init = (state == S_DECODE);
  assign it_adv  = (state == S_COMP) && cmp_done && !last_tile;

  cnn_tile_iter #(.TR(TR), .TC(TC), .TM(TM), .TN(TN), .DIM_W(DIM_W)) u_iter (
    .clk(clk), .rst(rst), .init(it_init), .adv(it_adv),
    .lim_r(cfg_q.r), .lim_c(cfg_q.c), .lim_m(cfg_q.m), .lim_n(cfg_q.n),
    .ext_r(ext_r), .ext_c(ext_c), .ext_m(ext_m), .ext_n(ext_n),
    .first_r(first_r), .last_r(last_r), .first_c(first_c), .last_c(last_c),
    .first_n(first_n), .last_n(last_n), .last_tile(last_tile)
  );

  // Burst lengths of the current tile.
  logic [LEN_W-1:0] e_r, e_c, e_m, e_n, k_h, k_w, s_l, pd, ih, iw, wlen, ilen, olen;
  always_comb begin
    e_r  = LEN_W'(ext_r);
    e_c  = LEN_W'(ext_c);
    e_m  = LEN_W'(ext_m);
    e_n  = LEN_W'(ext_n);
    k_h  = LEN_W'(cfg_q.kh);
    k_w  = LEN_W'(cfg_q.kw);
    s_l  = LEN_W'(cfg_q.s);
    pd   = LEN_W'(cfg_q.pad);
    ih   = (e_r - LEN_W'(1)) * s_l + k_h - (first_r ? pd : '0) - (last_r ? pd : '0);
    iw   = (e_c - LEN_W'(1)) * s_l + k_w - (first_c ? pd : '0) - (last_c ? pd : '0);
    wlen = e_m * e_n * k_h * k_w;
    ilen = e_n * ih * iw;
    olen = e_m * e_r * e_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;      ld_st <= LS_IDLE;
      ld_req <= 1'b0;       ld_kind <= KIND_INSTR;
      ld_addr <= '0;        ld_len <= '0;
      st_req <= 1'b0;       st_addr <= '0;        st_len <= '0;
      cmp_start <= 1'b0;    cmp_clear <= 1'b0;
      cmp_relu <= 1'b0;     cmp_pool <= '0;       done <= 1'b0;
      instr_q <= '0;        cfg_q <= '0;
      layer_idx <= '0;      layer_cnt_q <= '0;
      wptr <= '0;           iptr <= '0;           optr <= '0;
    end else begin
      cmp_start <= 1'b0;
      done      <= 1'b0;
      if (st_req && st_ack) st_req <= 1'b0;

      // Load stream: weight burst, then input burst.
      case (ld_st)
        LS_W_ISSUE: begin
          ld_req <= 1'b1; ld_kind <= KIND_WGT;
          ld_addr <= WGT_BASE + wptr; ld_len <= wlen;
          wptr <= wptr + ADDR_W'(wlen);
          ld_st <= LS_W_WAIT;
        end
        LS_W_WAIT: if (ld_ack) begin ld_req <= 1'b0; ld_st <= LS_I_ISSUE; end
        LS_I_ISSUE: begin
          ld_req <= 1'b1; ld_kind <= KIND_IFM;
          ld_addr <= IFM_BASE + iptr; ld_len <= ilen;
          iptr <= iptr + ADDR_W'(ilen);
          ld_st <= LS_I_WAIT;
        end
        LS_I_WAIT: if (ld_ack) begin ld_req <= 1'b0; ld_st <= LS_IDLE; end
        default: ;
      endcase

      case (state)
        S_IDLE: if (start && layer_cnt != '0) begin
          layer_cnt_q <= layer_cnt;  layer_idx <= '0;
          wptr <= '0; iptr <= '0; optr <= '0;
          ld_req <= 1'b1; ld_kind <= KIND_INSTR;
          ld_addr <= INSTR_BASE; ld_len <= LEN_W'(1);
          state <= S_FETCH;
        end
        S_FETCH: if (ld_ack) begin
          instr_q <= instr_t'(ld_rdata);
          ld_req <= 1'b0;
          state <= S_DECODE;
        end
        S_DECODE: begin
          cfg_q <= dec_cfg;
          ld_st <= LS_W_ISSUE;
          state <= S_LOAD;
        end
        S_LOAD: if (ld_st == LS_IDLE && !st_req) begin
          cmp_start <= 1'b1;
          cmp_clear <= first_n;
          cmp_relu  <= cfg_q.relu;
          cmp_pool  <= cfg_q.pool;
          state <= S_COMP;
        end
        S_COMP: if (cmp_done) begin
          if (last_n) begin
            st_req <= 1'b1; st_addr <= OFM_BASE + optr; st_len <= olen;
            optr <= optr + ADDR_W'(olen);
          end
          if (!last_tile) begin
            ld_st <= LS_W_ISSUE;
            state <= S_LOAD;
          end else begin
            state <= S_DRAIN;
          end
        end
        S_DRAIN: if (!st_req) begin
          if (layer_idx + CNT_W'(1) == layer_cnt_q) begin
            done <= 1'b1;
            state <= S_IDLE;
          end else begin
            layer_idx <= layer_idx + CNT_W'(1);
            ld_req <= 1'b1; ld_kind <= KIND_INSTR;
            ld_addr <= INSTR_BASE + ADDR_W'(layer_idx) + ADDR_W'(1);
            ld_len <= LEN_W'(1);
            state <= S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r9_ld_hold: assert property (@(posedge clk) disable iff (rst)
    (ld_req && !ld_ack) |=> (ld_req && $stable(ld_kind) && $stable(ld_addr) && $stable(ld_len)));

  a_r7_st_hold: assert property (@(posedge clk) disable iff (rst)
    (st_req && !st_ack) |=> (st_req && $stable(st_addr) && $stable(st_len)));

  a_r8_cmp_gated: assert property (@(posedge clk) disable iff (rst)
    cmp_start |-> (!ld_req && !st_req));

  a_r8_store_free: assert property (@(posedge clk) disable iff (rst)
    (state == S_COMP && cmp_done && last_n) |-> !st_req);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_fetch_single: assert property (@(posedge clk) disable iff (rst)
    (ld_req && ld_kind == KIND_INSTR) |-> (ld_len == LEN_W'(1)));

endmodule

// File: tb/tb_cnn_tile_seq.sv
`timescale 1ns/1ps
module tb_cnn_tile_seq;
  import cnn_seq_pkg::*;

  localparam int TR = 2, TC = 4, TM = 2, TN = 4;
  localparam int IB = 'h1000, WB = 'h10_0000, FB = 'h40_0000, OB = 'h80_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, start, ld_req, ld_ack, st_req, st_ack;
  logic cmp_start, cmp_clear, cmp_relu, cmp_done, done;
  logic [7:0] layer_cnt;
  logic [1:0] ld_kind;
  logic [31:0] ld_addr, ld_len, st_addr, st_len;
  logic [INSTR_W-1:0] ld_rdata;
  logic [3:0] cmp_pool;

  cnn_tile_seq #(.TR(TR), .TC(TC), .TM(TM), .TN(TN)) dut (
    .clk(clk), .rst(rst), .start(start), .layer_cnt(layer_cnt),
    .ld_req(ld_req), .ld_kind(ld_kind), .ld_addr(ld_addr), .ld_len(ld_len),
    .ld_ack(ld_ack), .ld_rdata(ld_rdata),
    .st_req(st_req), .st_addr(st_addr), .st_len(st_len), .st_ack(st_ack),
    .cmp_start(cmp_start), .cmp_clear(cmp_clear), .cmp_relu(cmp_relu),
    .cmp_pool(cmp_pool), .cmp_done(cmp_done), .done(done)
  );

  int n_chk = 0, n_fail = 0, done_cnt = 0;
  bit wd_hit = 0, saw_ovl = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard queues.
  int q_lk[$], q_la[$], q_ll[$];  string q_lt[$];
  int q_sa[$], q_sl[$];           string q_st[$];
  int q_cc[$], q_cr[$], q_cp[$];
  logic [INSTR_W-1:0] imem [4];
  int wp, ip, op;

  // R3: field order of the instruction word.
  function automatic logic [INSTR_W-1:0] pack(int fcn, int nin, int nout, int rows, int cols,
                                              int k, int s, int pad, int relu, int pool);
    return {1'(fcn), 16'(nin), 16'(nout), 12'(rows), 12'(cols), 4'(k), 4'(s), 4'(pad),
            1'(relu), 4'(pool)};
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // Driver: builds the expected event streams for one layer.
  task automatic add_layer(int idx, int fcn, int nin, int nout, int rows, int cols,
                           int k, int s, int pad, int relu, int pool, string tag);
    int N, M, R, C, kh, kw, S, P;
    imem[idx] = pack(fcn, nin, nout, rows, cols, k, s, pad, relu, pool);
    if (fcn != 0) begin   // R10 rewrite
      N = nin >> k; M = rows; R = 1; C = nout; kh = 1; kw = 1 << k; S = 1 << k; P = 0;
    end else begin
      N = nin; M = nout; R = rows; C = cols; kh = k; kw = k; S = s; P = pad;
    end
    q_lk.push_back(0); q_la.push_back(IB + idx); q_ll.push_back(1); q_lt.push_back("R2 R3");
    for (int r0 = 0; r0 < R; r0 += TR)
      for (int c0 = 0; c0 < C; c0 += TC)
        for (int m0 = 0; m0 < M; m0 += TM)
          for (int n0 = 0; n0 < N; n0 += TN) begin
            int tr, tc, tm, tn, ih, iw, wl, il;
            tr = imin(TR, R - r0); tc = imin(TC, C - c0);
            tm = imin(TM, M - m0); tn = imin(TN, N - n0);
            wl = tm * tn * kh * kw;
            ih = (tr - 1) * S + kh - ((r0 == 0) ? P : 0) - ((r0 + TR >= R) ? P : 0);
            iw = (tc - 1) * S + kw - ((c0 == 0) ? P : 0) - ((c0 + TC >= C) ? P : 0);
            il = tn * ih * iw;
            q_lk.push_back(1); q_la.push_back(WB + wp); q_ll.push_back(wl);
            q_lt.push_back({tag, " R5 R4"});
            wp += wl;
            q_lk.push_back(2); q_la.push_back(FB + ip); q_ll.push_back(il);
            q_lt.push_back({tag, " R6 R4"});
            ip += il;
            q_cc.push_back((n0 == 0) ? 1 : 0); q_cr.push_back(relu); q_cp.push_back(pool);
            if (n0 + TN >= N) begin
              q_sa.push_back(OB + op); q_sl.push_back(tm * tr * tc);
              q_st.push_back({tag, " R7"});
              op += tm * tr * tc;
            end
          end
  endtask

  // Load-channel memory model and monitor.
  initial begin
    int cnt, nreq, cur_kind, cur_addr, k, a, l;
    string t;
    bit busy;
    ld_ack = 0; ld_rdata = '0; busy = 0; cnt = 0; nreq = 0; cur_kind = 0; cur_addr = 0;
    forever begin
      @(negedge clk);
      if (ld_req && st_req) saw_ovl = 1;
      if (ld_ack) ld_ack = 0;
      else if (busy) begin
        if (cnt == 0) begin
          ld_ack = 1; busy = 0;
          if (cur_kind == 0) ld_rdata = imem[(cur_addr - IB) & 3];
        end else cnt--;
      end else if (ld_req && !rst) begin
        if (q_lk.size() == 0) chk(0, "R9 unexpected load", int'(ld_kind), -1);
        else begin
          k = q_lk.pop_front(); a = q_la.pop_front(); l = q_ll.pop_front(); t = q_lt.pop_front();
          chk(int'(ld_kind) == k, {t, " R9 kind"}, int'(ld_kind), k);
          chk(int'(ld_addr) == a, {t, " addr"}, int'(ld_addr), a);
          chk(int'(ld_len) == l, {t, " len"}, int'(ld_len), l);
        end
        cur_kind = int'(ld_kind); cur_addr = int'(ld_addr);
        busy = 1; cnt = nreq % 3; nreq++;
      end
    end
  end

  // Store-channel memory model and monitor (slow, to expose overlap).
  initial begin
    int cnt, nreq, a, l;
    string t;
    bit busy;
    st_ack = 0; busy = 0; cnt = 0; nreq = 0;
    forever begin
      @(negedge clk);
      if (st_ack) st_ack = 0;
      else if (busy) begin
        if (cnt == 0) begin st_ack = 1; busy = 0; end else cnt--;
      end else if (st_req && !rst) begin
        if (q_sa.size() == 0) chk(0, "R7 unexpected store", int'(st_addr), -1);
        else begin
          a = q_sa.pop_front(); l = q_sl.pop_front(); t = q_st.pop_front();
          chk(int'(st_addr) == a, {t, " addr"}, int'(st_addr), a);
          chk(int'(st_len) == l, {t, " len"}, int'(st_len), l);
        end
        busy = 1; cnt = 4 + nreq % 4; nreq++;
      end
    end
  end

  // Compute-engine model and monitor.
  initial begin
    int cnt, c, r, p;
    bit busy;
    cmp_done = 0; busy = 0; cnt = 0;
    forever begin
      @(negedge clk);
      if (cmp_done) cmp_done = 0;
      else if (busy) begin
        if (cnt == 0) begin cmp_done = 1; busy = 0; end else cnt--;
      end
      if (cmp_start && !rst) begin
        chk(!ld_req && !st_req, "R8 compute start gated", {ld_req, st_req}, 0);
        if (q_cc.size() == 0) chk(0, "R12 unexpected compute", 1, 0);
        else begin
          c = q_cc.pop_front(); r = q_cr.pop_front(); p = q_cp.pop_front();
          chk(int'(cmp_clear) == c, "R12 clear", int'(cmp_clear), c);
          chk(int'(cmp_relu) == r, "R12 relu", int'(cmp_relu), r);
          chk(int'(cmp_pool) == p, "R12 pool", int'(cmp_pool), p);
        end
        busy = 1; cnt = 2;
      end
    end
  end

  // Done monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (done && !rst) begin
        done_cnt++;
        chk(!st_req && q_sa.size() == 0 && q_lk.size() == 0, "R11 done after final store",
            q_sa.size() + q_lk.size(), 0);
      end
    end
  end

  // Watchdog.
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 100000) begin
        wd_hit = 1; n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      end
    end
  end

  task automatic wait_done(int target);
    while (done_cnt < target && !wd_hit) @(negedge clk);
  endtask

  initial begin
    rst = 1; start = 0; layer_cnt = 0;
    repeat (3) @(negedge clk);
    chk(!ld_req && !st_req && !cmp_start && !done, "R1 reset outputs",
        {ld_req, st_req, cmp_start, done}, 0);
    rst = 0;
    @(negedge clk);
    chk(!ld_req && !st_req && !cmp_start && !done, "R1 idle after reset",
        {ld_req, st_req, cmp_start, done}, 0);

    // R11: zero layer count is ignored.
    start = 1; layer_cnt = 0;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    chk(!ld_req && !st_req, "R11 zero count no request", {ld_req, st_req}, 0);

    // Run 1: ragged conv, fully connected, stride-2 conv.
    wp = 0; ip = 0; op = 0;
    add_layer(0, 0, 5, 3, 4, 5, 3, 1, 1, 1, 2, "conv");
    add_layer(1, 1, 16, 6, 3, 0, 2, 0, 0, 0, 1, "R10 fcn");
    add_layer(2, 0, 2, 2, 2, 2, 3, 2, 0, 1, 0, "conv");
    layer_cnt = 3; start = 1;
    @(negedge clk);
    start = 0;
    wait_done(1);
    repeat (6) @(negedge clk);
    chk(done_cnt == 1, "R11 single done pulse", done_cnt, 1);
    chk(q_lk.size() == 0 && q_sa.size() == 0 && q_cc.size() == 0, "R2 all events seen",
        q_lk.size() + q_sa.size() + q_cc.size(), 0);
    chk(saw_ovl, "R8 load and store overlap", saw_ovl, 1);

    // Run 2: many input groups, stores only on the last one.
    wp = 0; ip = 0; op = 0;
    add_layer(0, 0, 9, 2, 3, 3, 1, 1, 0, 0, 0, "conv deep");
    layer_cnt = 1; start = 1;
    @(negedge clk);
    start = 0;
    wait_done(2);
    repeat (6) @(negedge clk);
    chk(done_cnt == 2, "R11 second run done", done_cnt, 2);
    chk(q_sa.size() == 0 && q_lk.size() == 0 && q_cc.size() == 0, "R7 no extra stores",
        q_sa.size() + q_lk.size() + q_cc.size(), 0);
    chk(!ld_req && !st_req, "R11 idle after run", {ld_req, st_req}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule